// File: doc/BRIEF.md
# Reduced RV32I Instruction Decoder

This block turns one 32-bit instruction word into the control bundle an execute stage needs. It covers a 33-instruction subset of the RV32I base set: the register-register and register-immediate arithmetic and logic operations, the five loads, the three stores, the six conditional branches, `lui`, `jal` and `jalr`. For each word it gives the three register specifiers, an ALU operation code, the immediate reassembled from its scattered bit fields and sign-extended, and the control flags for register write-back, memory access, branching and jumping.

Every word outside the subset is marked illegal. This includes encodings that the full base set accepts, such as shift-immediates, fence and system instructions. An illegal word drives no enable. The decode logic is combinational. A parameter places an output register after it, which gives one cycle of latency and a synchronous active-low reset, or leaves the path combinational.

Top module: `rv_subset_decoder`

## Requirements
- R1: `rd_o`, `rs1_o` and `rs2_o` always carry instruction bits 11:7, 19:15 and 24:20, legal word or not.
- R2: Opcode 0110011 decodes as follows, with func3 in bits 14:12 and func7 in bits 31:25. `alu_op_o` is 0 for add (000/0000000), 1 for sub (000/0100000), 2 for sll (001), 3 for slt (010), 4 for sltu (011), 5 for xor (100), 6 for srl (101/0000000), 7 for sra (101/0100000), 8 for or (110) and 9 for and (111). Func7 must be 0000000 except for sub and sra. `use_imm_o` is 0 and `imm_o` is 0.
- R3: Opcode 0010011 with func3 000, 010, 011, 100, 110 or 111 gives `alu_op_o` 0, 3, 4, 5, 8 or 9 respectively. `use_imm_o` is 1 and `imm_o` is bits 31:20 sign-extended.
- R4: Opcode 0000011 with func3 000, 001, 010, 100 or 101 sets `mem_rd_o`. `mem_size_o` is then 0 for byte, 1 for half and 2 for word. `mem_unsigned_o` is 1 only for func3 100 and 101. `alu_op_o` is 0, `use_imm_o` is 1 and the immediate is in the same format as R3.
- R5: Opcode 0100011 with func3 000, 001 or 010 sets `mem_wr_o`, with `mem_size_o` equal to func3[1:0]. `imm_o` is {bits 31:25, bits 11:7} sign-extended. `reg_we_o` is 0.
- R6: Opcode 1100011 with func3 000, 001, 100, 101, 110 or 111 sets `is_branch_o` and gives `br_cond_o` equal to func3. `imm_o` is {b31, b7, b30:25, b11:8, 0} sign-extended. `reg_we_o` is 0.
- R7: Opcode 0110111 gives `imm_o` equal to {bits 31:12, twelve zeros}, `alu_op_o` 10 (pass operand B), `use_imm_o` 1 and a register write.
- R8: Opcode 1101111 gives `jump_o` 1 with `imm_o` {b31, b19:12, b20, b30:21, 0} sign-extended. Opcode 1100111 with func3 000 gives `jump_o` 2 with the immediate in the same format as R3 and `use_imm_o` 1. Both write rd.
- R9: `reg_we_o` is 1 exactly when the word is legal, belongs to the arithmetic, load, `lui` or jump groups, and rd is not 0.
- R10: Every other opcode/func3/func7 combination sets `illegal_o`. In that case `reg_we_o`, `mem_rd_o`, `mem_wr_o`, `is_branch_o`, `jump_o`, `use_imm_o`, `mem_size_o`, `mem_unsigned_o`, `br_cond_o`, `alu_op_o` and `imm_o` are all 0.
- R11: With the default `REG_OUT`=1, outputs follow the input word one clock later. While `rst_n` is low at a rising edge, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word to decode |
| rd_o | output | 5 | Destination register specifier |
| rs1_o | output | 5 | First source register specifier |
| rs2_o | output | 5 | Second source register specifier |
| alu_op_o | output | 4 | ALU operation code |
| imm_o | output | 32 | Reassembled, sign-extended immediate |
| use_imm_o | output | 1 | ALU operand B takes the immediate |
| reg_we_o | output | 1 | Register write-back enable |
| mem_rd_o | output | 1 | Memory load |
| mem_wr_o | output | 1 | Memory store |
| mem_size_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_unsigned_o | output | 1 | Load is zero-extended |
| is_branch_o | output | 1 | Conditional branch |
| br_cond_o | output | 3 | Branch condition (func3) |
| jump_o | output | 2 | 0 none, 1 jal, 2 jalr |
| illegal_o | output | 1 | Word is outside the subset |

## Verification
The hardest cases to reach are the near-misses. These words carry a valid opcode but a func3 or func7 that the full base set accepts and this subset does not: shift-immediates, register ops with a nonzero unlisted func7, `jalr` with nonzero func3, and the unused load, store and branch func3 codes. Random words seldom land on them. The stimulus therefore lists them directly. It then sends biased random words that pick a known opcode most of the time and leave func3, func7 and the register fields free, so that rd equal to 0 and every immediate sign case come up often.

// File: rtl/rvd_pkg.sv
// Shared definitions for the reduced instruction decoder.
// Assumes 32-bit instruction words and 32 architectural registers.
package rvd_pkg;
    localparam int ILEN   = 32;
    localparam int XLEN   = 32;
    localparam int RAW    = 5;
    localparam int OPW    = 7;
    localparam int F3W    = 3;
    localparam int F7W    = 7;
    localparam int AOPW   = 4;

    localparam logic [OPW-1:0] OPC_REG   = 7'b0110011;
    localparam logic [OPW-1:0] OPC_IMM   = 7'b0010011;
    localparam logic [OPW-1:0] OPC_LOAD  = 7'b0000011;
    localparam logic [OPW-1:0] OPC_STORE = 7'b0100011;
    localparam logic [OPW-1:0] OPC_BR    = 7'b1100011;
    localparam logic [OPW-1:0] OPC_LUI   = 7'b0110111;
    localparam logic [OPW-1:0] OPC_JAL   = 7'b1101111;
    localparam logic [OPW-1:0] OPC_JALR  = 7'b1100111;

    localparam logic [F7W-1:0] F7_BASE = 7'b0000000;
    localparam logic [F7W-1:0] F7_ALT  = 7'b0100000;

    typedef enum logic [AOPW-1:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_SLL   = 4'd2,
        ALU_SLT   = 4'd3,
        ALU_SLTU  = 4'd4,
        ALU_XOR   = 4'd5,
        ALU_SRL   = 4'd6,
        ALU_SRA   = 4'd7,
        ALU_OR    = 4'd8,
        ALU_AND   = 4'd9,
        ALU_PASSB = 4'd10
    } alu_op_e;

    typedef enum logic [2:0] {
        FMT_NONE, FMT_R, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
    } fmt_e;

    typedef enum logic [1:0] {
        JMP_NONE = 2'd0,
        JMP_JAL  = 2'd1,
        JMP_JALR = 2'd2
    } jump_e;

    typedef struct packed {
        logic [RAW-1:0]  rd;
        logic [RAW-1:0]  rs1;
        logic [RAW-1:0]  rs2;
        logic [AOPW-1:0] alu_op;
        logic [XLEN-1:0] imm;
        logic            use_imm;
        logic            reg_we;
        logic            mem_rd;
        logic            mem_wr;
        logic [1:0]      mem_size;
        logic            mem_unsigned;
        logic            is_branch;
        logic [F3W-1:0]  br_cond;
        logic [1:0]      jump;
        logic            illegal;
    } dec_t;
endpackage

// File: rtl/rvd_ctrl.sv
// Classifies an instruction word against the supported subset and
// produces every control field except the immediate value.
// Assumes: purely combinational; unsupported words yield all-zero
// controls with illegal set and format FMT_NONE.
module rvd_ctrl
    import rvd_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output fmt_e            fmt_o,
    output logic [AOPW-1:0] alu_op_o,
    output logic            use_imm_o,
    output logic            reg_we_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic [1:0]      mem_size_o,
    output logic            mem_unsigned_o,
    output logic            is_branch_o,
    output logic [F3W-1:0]  br_cond_o,
    output logic [1:0]      jump_o,
    output logic            illegal_o
);
    logic [OPW-1:0] opc;
    logic [F3W-1:0] f3;
    logic [F7W-1:0] f7;
    logic [RAW-1:0] rd;
    logic           legal;
    logic           wants_wb;
    fmt_e           fmt_c;
    alu_op_e        op_c;
    logic           uimm_c, mrd_c, mwr_c, muns_c, br_c;
    logic [1:0]     msz_c;
    jump_e          jmp_c;

    assign opc = instr_i[6:0];
    assign rd  = instr_i[11:7];
    assign f3  = instr_i[14:12];
    assign f7  = instr_i[31:25];

    // Match opcode and function fields against the subset.
    always_comb begin
        legal    = 1'b0;
        wants_wb = 1'b0;
        fmt_c    = FMT_NONE;
        op_c     = ALU_ADD;
        uimm_c   = 1'b0;
        mrd_c    = 1'b0;
        mwr_c    = 1'b0;
        msz_c    = 2'd0;
        muns_c   = 1'b0;
        br_c     = 1'b0;
        jmp_c    = JMP_NONE;
        case (opc)
            OPC_REG: begin
                fmt_c    = FMT_R;
                wants_wb = 1'b1;
                case (f3)
                    3'b000: begin
                        legal = (f7 == F7_BASE) || (f7 == F7_ALT);
                        op_c  = (f7 == F7_ALT) ? ALU_SUB : ALU_ADD;
                    end
                    3'b101: begin
                        legal = (f7 == F7_BASE) || (f7 == F7_ALT);
                        op_c  = (f7 == F7_ALT) ? ALU_SRA : ALU_SRL;
                    end
                    3'b001: begin legal = (f7 == F7_BASE); op_c = ALU_SLL;  end
                    3'b010: begin legal = (f7 == F7_BASE); op_c = ALU_SLT;  end
                    3'b011: begin legal = (f7 == F7_BASE); op_c = ALU_SLTU; end
                    3'b100: begin legal = (f7 == F7_BASE); op_c = ALU_XOR;  end
                    3'b110: begin legal = (f7 == F7_BASE); op_c = ALU_OR;   end
                    default: begin legal = (f7 == F7_BASE); op_c = ALU_AND; end
                endcase
            end
            OPC_IMM: begin
                fmt_c    = FMT_I;
                wants_wb = 1'b1;
                uimm_c   = 1'b1;
                legal    = 1'b1;
                case (f3)
                    3'b000:  op_c = ALU_ADD;
                    3'b010:  op_c = ALU_SLT;
                    3'b011:  op_c = ALU_SLTU;
                    3'b100:  op_c = ALU_XOR;
                    3'b110:  op_c = ALU_OR;
                    3'b111:  op_c = ALU_AND;
                    default: legal = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                fmt_c    = FMT_I;
                wants_wb = 1'b1;
                uimm_c   = 1'b1;
                mrd_c    = 1'b1;
                msz_c    = f3[1:0];
                muns_c   = f3[2];
                legal    = (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b010) ||
                           (f3 == 3'b100) || (f3 == 3'b101);
            end
            OPC_STORE: begin
                fmt_c  = FMT_S;
                uimm_c = 1'b1;
                mwr_c  = 1'b1;
                msz_c  = f3[1:0];
                legal  = (f3[2] == 1'b0) && (f3[1:0] != 2'b11);
            end
            OPC_BR: begin
                fmt_c = FMT_B;
                br_c  = 1'b1;
                legal = (f3[2:1] != 2'b01);
            end
            OPC_LUI: begin
                fmt_c    = FMT_U;
                wants_wb = 1'b1;
                uimm_c   = 1'b1;
                op_c     = ALU_PASSB;
                legal    = 1'b1;
            end
            OPC_JAL: begin
                fmt_c    = FMT_J;
                wants_wb = 1'b1;
                jmp_c    = JMP_JAL;
                legal    = 1'b1;
            end
            OPC_JALR: begin
                fmt_c    = FMT_I;
                wants_wb = 1'b1;
                uimm_c   = 1'b1;
                jmp_c    = JMP_JALR;
                legal    = (f3 == 3'b000);
            end
            default: legal = 1'b0;
        endcase
    end

    // Gate every control with legality; write-back also needs rd != 0.
    always_comb begin
        fmt_o          = legal ? fmt_c : FMT_NONE;
        alu_op_o       = legal ? op_c : ALU_ADD;
        use_imm_o      = legal & uimm_c;
        reg_we_o       = legal & wants_wb & (rd != '0);
        mem_rd_o       = legal & mrd_c;
        mem_wr_o       = legal & mwr_c;
        mem_size_o     = legal ? msz_c : 2'd0;
        mem_unsigned_o = legal & muns_c;
        is_branch_o    = legal & br_c;
        br_cond_o      = (legal & br_c) ? f3 : '0;
        jump_o         = legal ? jmp_c : JMP_NONE;
        illegal_o      = ~legal;
    end
endmodule

// File: rtl/rvd_immgen.sv
// Reassembles and sign-extends the immediate for the selected format.
// Assumes: FMT_R and FMT_NONE carry no immediate and produce zero.
module rvd_immgen
    import rvd_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    input  fmt_e            fmt_i,
    output logic [XLEN-1:0] imm_o
);
    localparam int IW = 12;
    localparam int BW = 13;
    localparam int JW = 21;
    localparam int UW = 20;

    logic [IW-1:0] raw_i, raw_s;
    logic [BW-1:0] raw_b;
    logic [JW-1:0] raw_j;
    logic [UW-1:0] raw_u;

    assign raw_i = instr_i[31:20];
    assign raw_s = {instr_i[31:25], instr_i[11:7]};
    assign raw_b = {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
    assign raw_j = {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
    assign raw_u = instr_i[31:12];

    // Choose the format and sign-extend from its top bit.
    always_comb begin
        case (fmt_i)
            FMT_I:   imm_o = {{(XLEN-IW){raw_i[IW-1]}}, raw_i};
            FMT_S:   imm_o = {{(XLEN-IW){raw_s[IW-1]}}, raw_s};
            FMT_B:   imm_o = {{(XLEN-BW){raw_b[BW-1]}}, raw_b};
            FMT_J:   imm_o = {{(XLEN-JW){raw_j[JW-1]}}, raw_j};
            FMT_U:   imm_o = {raw_u, {(XLEN-UW){1'b0}}};
            default: imm_o = '0;
        endcase
    end
endmodule

// File: rtl/rvd_outstage.sv
// Optional output register for the decoded bundle.
// Assumes: REG_OUT=1 registers with synchronous active-low reset to
// all zeros; REG_OUT=0 passes the bundle straight through.
module rvd_outstage
    import rvd_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  dec_t d_i,
    output dec_t q_o
);
    generate
        if (REG_OUT) begin : g_reg
            dec_t q_r;
            // Capture the decode result each cycle; clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_wire
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/rv_subset_decoder.sv
// Top of the reduced instruction decoder: field extraction, control
// classification, immediate reassembly and the optional output stage.
// Assumes one instruction word per cycle; no handshake.
module rv_subset_decoder
    import rvd_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr_i,
    output logic [4:0]      rd_o,
    output logic [4:0]      rs1_o,
    output logic [4:0]      rs2_o,
    output logic [3:0]      alu_op_o,
    output logic [31:0]     imm_o,
    output logic            use_imm_o,
    output logic            reg_we_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic [1:0]      mem_size_o,
    output logic            mem_unsigned_o,
    output logic            is_branch_o,
    output logic [2:0]      br_cond_o,
    output logic [1:0]      jump_o,
    output logic            illegal_o
);
    fmt_e fmt;
    dec_t dec_c;
    dec_t dec_q;

    assign dec_c.rd  = instr_i[11:7];
    assign dec_c.rs1 = instr_i[19:15];
    assign dec_c.rs2 = instr_i[24:20];

    rvd_ctrl u_ctrl (
        .instr_i        (instr_i),
        .fmt_o          (fmt),
        .alu_op_o       (dec_c.alu_op),
        .use_imm_o      (dec_c.use_imm),
        .reg_we_o       (dec_c.reg_we),
        .mem_rd_o       (dec_c.mem_rd),
        .mem_wr_o       (dec_c.mem_wr),
        .mem_size_o     (dec_c.mem_size),
        .mem_unsigned_o (dec_c.mem_unsigned),
        .is_branch_o    (dec_c.is_branch),
        .br_cond_o      (dec_c.br_cond),
        .jump_o         (dec_c.jump),
        .illegal_o      (dec_c.illegal)
    );

    rvd_immgen u_imm (
        .instr_i (instr_i),
        .fmt_i   (fmt),
        .imm_o   (dec_c.imm)
    );

    rvd_outstage #(.REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dec_c),
        .q_o   (dec_q)
    );

    assign rd_o           = dec_q.rd;
    assign rs1_o          = dec_q.rs1;
    assign rs2_o          = dec_q.rs2;
    assign alu_op_o       = dec_q.alu_op;
    assign imm_o          = dec_q.imm;
    assign use_imm_o      = dec_q.use_imm;
    assign reg_we_o       = dec_q.reg_we;
    assign mem_rd_o       = dec_q.mem_rd;
    assign mem_wr_o       = dec_q.mem_wr;
    assign mem_size_o     = dec_q.mem_size;
    assign mem_unsigned_o = dec_q.mem_unsigned;
    assign is_branch_o    = dec_q.is_branch;
    assign br_cond_o      = dec_q.br_cond;
    assign jump_o         = dec_q.jump;
    assign illegal_o      = dec_q.illegal;

    // Output-side invariants on the bundle leaving the block.
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!reg_we_o && !mem_rd_o && !mem_wr_o && !is_branch_o &&
                       jump_o == 2'd0 && imm_o == '0));
    a_r9_no_write_r0: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (rd_o != 5'd0));
    a_r5_r6_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o || is_branch_o) |-> !reg_we_o);
    a_r10_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o, is_branch_o, jump_o != 2'd0}));
    a_r4_unsigned_load: assert property (@(posedge clk) disable iff (!rst_n)
        mem_unsigned_o |-> (mem_rd_o && mem_size_o != 2'd2));
    a_r6_branch_cond: assert property (@(posedge clk) disable iff (!rst_n)
        is_branch_o |-> (br_cond_o[2:1] != 2'b01 && imm_o[0] == 1'b0));
    a_r7_upper_imm: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op_o == 4'd10) |-> (imm_o[11:0] == 12'd0 && use_imm_o));
endmodule

// File: tb/rv_subset_decoder_bench.sv
`timescale 1ns/1ps
module rv_subset_decoder_bench;
    import rvd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [4:0]  rd, rs1, rs2;
    logic [3:0]  alu_op;
    logic [31:0] imm;
    logic        use_imm, reg_we, mem_rd, mem_wr, mem_uns, is_br, illegal;
    logic [1:0]  mem_size, jump;
    logic [2:0]  br_cond;

    int n_vec = 0;
    int n_bad = 0;
    dec_t exp_q[$];
    logic [31:0] ins_q[$];

    always #2.5 clk = ~clk;

    rv_subset_decoder u_rv_subset_decoder (
        .clk(clk), .rst_n(rst_n), .instr_i(instr),
        .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2), .alu_op_o(alu_op), .imm_o(imm),
        .use_imm_o(use_imm), .reg_we_o(reg_we), .mem_rd_o(mem_rd),
        .mem_wr_o(mem_wr), .mem_size_o(mem_size), .mem_unsigned_o(mem_uns),
        .is_branch_o(is_br), .br_cond_o(br_cond), .jump_o(jump),
        .illegal_o(illegal)
    );

    // Behavioural reference: arithmetic immediates, rule table per opcode.
    function automatic dec_t model(input logic [31:0] w);
        dec_t e;
        int   op, f3, f7, v;
        bit   ok, wb;
        e = '0;
        op = int'(w[6:0]); f3 = int'(w[14:12]); f7 = int'(w[31:25]);
        e.rd = w[11:7]; e.rs1 = w[19:15]; e.rs2 = w[24:20];
        ok = 0; wb = 0;
        if (op == 'h33) begin
            wb = 1;
            if (f7 == 0) begin
                ok = 1;
                e.alu_op = (f3 == 0) ? 4'd0 : (f3 == 1) ? 4'd2 : (f3 == 2) ? 4'd3 :
                           (f3 == 3) ? 4'd4 : (f3 == 4) ? 4'd5 : (f3 == 5) ? 4'd6 :
                           (f3 == 6) ? 4'd8 : 4'd9;
            end else if (f7 == 'h20 && (f3 == 0 || f3 == 5)) begin
                ok = 1;
                e.alu_op = (f3 == 0) ? 4'd1 : 4'd7;
            end
        end else if (op == 'h13 && f3 != 1 && f3 != 5) begin
            ok = 1; wb = 1; e.use_imm = 1;
            e.alu_op = (f3 == 0) ? 4'd0 : (f3 == 2) ? 4'd3 : (f3 == 3) ? 4'd4 :
                       (f3 == 4) ? 4'd5 : (f3 == 6) ? 4'd8 : 4'd9;
        end else if (op == 'h03 && (f3 <= 2 || f3 == 4 || f3 == 5)) begin
            ok = 1; wb = 1; e.use_imm = 1; e.mem_rd = 1;
            e.mem_size = 2'(f3 % 4); e.mem_unsigned = (f3 >= 4);
        end else if (op == 'h23 && f3 <= 2) begin
            ok = 1; e.use_imm = 1; e.mem_wr = 1; e.mem_size = 2'(f3);
        end else if (op == 'h63 && f3 != 2 && f3 != 3) begin
            ok = 1; e.is_branch = 1; e.br_cond = 3'(f3);
        end else if (op == 'h37) begin
            ok = 1; wb = 1; e.use_imm = 1; e.alu_op = 4'd10;
        end else if (op == 'h6f) begin
            ok = 1; wb = 1; e.jump = 2'd1;
        end else if (op == 'h67 && f3 == 0) begin
            ok = 1; wb = 1; e.use_imm = 1; e.jump = 2'd2;
        end
        if (!ok) begin
            e.alu_op = 0; e.use_imm = 0; e.mem_rd = 0; e.mem_wr = 0;
            e.mem_size = 0; e.mem_unsigned = 0; e.is_branch = 0; e.br_cond = 0;
            e.jump = 0; e.illegal = 1; e.imm = 0;
        end else begin
            v = 0;
            if (op == 'h13 || op == 'h03 || op == 'h67)
                v = int'(w[30:20]) - (w[31] ? 2048 : 0);
            else if (op == 'h23)
                v = int'(w[30:25]) * 32 + int'(w[11:7]) - (w[31] ? 2048 : 0);
            else if (op == 'h63)
                v = int'(w[11:8]) * 2 + int'(w[30:25]) * 32 + int'(w[7]) * 2048
                    - (w[31] ? 4096 : 0);
            else if (op == 'h6f)
                v = int'(w[30:21]) * 2 + int'(w[20]) * 2048 + int'(w[19:12]) * 4096
                    - (w[31] ? 1048576 : 0);
            if (op == 'h37) e.imm = {w[31:12], 12'h000};
            else            e.imm = 32'(v);
            e.reg_we = wb && (w[11:7] != 0);
        end
        return e;
    endfunction

    task automatic chk(input string tag, input string fld, input logic [31:0] act,
                       input logic [31:0] exp, input logic [31:0] w);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s instr=%08h actual=%0h expected=%0h", tag, fld, w, act, exp);
        end
    endtask

    // One comparison of every output against the queued reference.
    task automatic compare();
        dec_t e;
        logic [31:0] w;
        e = exp_q.pop_front();
        w = ins_q.pop_front();
        n_vec++;
        chk("R1", "rd", 32'(rd), 32'(e.rd), w);
        chk("R1", "rs1", 32'(rs1), 32'(e.rs1), w);
        chk("R1", "rs2", 32'(rs2), 32'(e.rs2), w);
        chk("R2", "alu_op", 32'(alu_op), 32'(e.alu_op), w);
        chk("R3", "use_imm", 32'(use_imm), 32'(e.use_imm), w);
        chk("R8", "imm", imm, e.imm, w);
        chk("R9", "reg_we", 32'(reg_we), 32'(e.reg_we), w);
        chk("R4", "mem_rd", 32'(mem_rd), 32'(e.mem_rd), w);
        chk("R5", "mem_wr", 32'(mem_wr), 32'(e.mem_wr), w);
        chk("R4", "mem_size", 32'(mem_size), 32'(e.mem_size), w);
        chk("R4", "mem_uns", 32'(mem_uns), 32'(e.mem_unsigned), w);
        chk("R6", "is_branch", 32'(is_br), 32'(e.is_branch), w);
        chk("R6", "br_cond", 32'(br_cond), 32'(e.br_cond), w);
        chk("R8", "jump", 32'(jump), 32'(e.jump), w);
        chk("R10", "illegal", 32'(illegal), 32'(e.illegal), w);
    endtask

    // Drive at a falling edge; the word is captured at the next rising
    // edge (R11) and compared at the falling edge after that.
    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        if (exp_q.size() > 0) compare();
        instr = w;
        exp_q.push_back(model(w));
        ins_q.push_back(w);
    endtask

    function automatic logic [31:0] enc(input int op, input int f3, input int f7,
                                        input int rdv, input int r1, input int r2);
        return {7'(f7), 5'(r2), 5'(r1), 3'(f3), 5'(rdv), 7'(op)};
    endfunction

    initial begin : watchdog
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        int ops[8];
        ops = '{'h33, 'h13, 'h03, 'h23, 'h63, 'h37, 'h6f, 'h67};
        // R11: reset clears every output even with a legal word present.
        instr = enc('h33, 0, 0, 5, 6, 7);
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if ({rd, rs1, rs2, alu_op, imm, use_imm, reg_we, mem_rd, mem_wr, mem_size,
             mem_uns, is_br, br_cond, jump, illegal} !== '0) begin
            n_bad++;
            $display("FAIL R11 reset outputs actual=nonzero expected=0");
        end
        rst_n = 1'b1;
        // R2 register ops, including func7 near-misses.
        for (int f = 0; f < 8; f++) begin
            apply(enc('h33, f, 0, 3, 9, 17));
            apply(enc('h33, f, 'h20, 4, 10, 18));
            apply(enc('h33, f, 1, 5, 11, 19));
        end
        // R3 immediate ops, shift-immediates are illegal (R10).
        for (int f = 0; f < 8; f++) begin
            apply(enc('h13, f, 'h7f, 1, 2, 31));
            apply(enc('h13, f, 'h00, 7, 2, 5));
        end
        // R4 loads, R5 stores, R6 branches over all func3.
        for (int f = 0; f < 8; f++) begin
            apply(enc('h03, f, 'h40, 8, 1, 4));
            apply(enc('h23, f, 'h3f, 31, 2, 3));
            apply(enc('h63, f, 'h55, 1, 4, 5));
            apply(enc('h63, f, 'h2a, 30, 4, 5));
            apply(enc('h67, f, 'h70, 1, 1, 0));
        end
        // R7 lui, R8 jal with both immediate signs.
        apply(32'hfffff0b7);
        apply(32'h123450b7);
        apply(32'h800000ef);
        apply(32'h7ffff0ef);
        apply(32'h001000ef);
        // R9 rd = 0 for every write-back group.
        apply(enc('h33, 0, 0, 0, 1, 2));
        apply(enc('h13, 0, 5, 0, 1, 2));
        apply(enc('h03, 2, 0, 0, 1, 2));
        apply(32'h00001037);
        apply(32'h0000006f);
        apply(enc('h67, 0, 0, 0, 1, 0));
        // R10 system, fence, all ones, all zeros.
        apply(32'h00000073);
        apply(32'h0000000f);
        apply(32'hffffffff);
        apply(32'h00000000);
        // Biased random words across all groups.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            w = $urandom();
            if (i % 8 != 7) w[6:0] = 7'(ops[$urandom_range(0, 7)]);
            if (i % 5 == 0) w[11:7] = 5'd0;
            if (i % 3 == 0) w[31:25] = (i % 2 == 0) ? 7'h00 : 7'h20;
            apply(w);
        end
        @(negedge clk);
        if (exp_q.size() > 0) compare();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule